// File: doc/BRIEF.md
# Single-wire bus slave timing engine

This block is the bit layer of a slave on a single-wire, open-drain bus. It watches the sampled bus level with a free-running clock. It recognises bus resets and answers each one with a presence pulse. It turns every master-started time slot into one bit event for the logic above it. A slot starts on the master's falling edge. When the upper logic has armed a read, the engine returns the offered bit, and for a 0 it holds the line low. Otherwise it samples the line at a fixed point and reports the written bit.

Two timing sets are available: standard and overdrive. The `od_i` flag picks one. All internal windows are given in microseconds and scaled by a clock-per-microsecond parameter.

Each bit event carries its position within the current byte, counted from 0 in the order the bits arrive. Upper logic can therefore assemble bytes least significant bit first. A bus reset clears that position.

Top module: `swire_slave_phy`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, pull_o, rx_valid_o, tx_done_o and reset_seen_o are 0.
- R2: A low level held for 480 µs or more at standard speed produces exactly one reset_seen_o pulse, raised while the line is still low.
- R3: After a reset, once the line is high again, pull_o holds the line low through the window 60–72 µs (standard) or 7–10 µs (overdrive) after the rise. pull_o is released by 130 µs (standard) or 15 µs (overdrive) after the rise.
- R4: At overdrive, a low of 48 µs or more is a reset. At standard speed, a low of at most 120 µs is never a reset.
- R5: At standard speed, with no read armed, a slot of 1–15 µs low yields one rx_valid_o pulse with rx_bit_o=1. A slot of 60–120 µs low yields one pulse with rx_bit_o=0.
- R6: At overdrive, with no read armed, a low of 1–2 µs yields rx_bit_o=1 and a low of 8–15 µs yields rx_bit_o=0.
- R7: If tx_en_i=1 at the falling edge, the slot is a read.
  - With tx_bit_i=0, the line stays low until at least 30 µs (standard) or 4 µs (overdrive) after the edge, so the master reads 0.
  - With tx_bit_i=1, the line is not pulled.
  - Either way the slot gives one tx_done_o pulse and no rx_valid_o.
- R8: bit_pos_o, valid with each rx_valid_o or tx_done_o pulse, counts slots 0,1,…,7 and then wraps to 0. Placing each received bit at bit_pos_o rebuilds the byte sent least significant bit first.
- R9: A reset part-way through a byte makes the next slot report bit_pos_o=0.
- R10: pull_o is never asserted during a write slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Bus level (1 = released/high) |
| od_i | input | 1 | 1 selects overdrive timing, 0 standard |
| tx_en_i | input | 1 | Arms the next slot as a read |
| tx_bit_i | input | 1 | Bit returned in an armed read slot |
| pull_o | output | 1 | 1 pulls the open-drain line low |
| rx_valid_o | output | 1 | One-cycle pulse: a written bit was received |
| rx_bit_o | output | 1 | Received bit, valid with rx_valid_o |
| tx_done_o | output | 1 | One-cycle pulse: a read slot completed |
| bit_pos_o | output | 3 | Position of the reported bit within the byte |
| reset_seen_o | output | 1 | One-cycle pulse: bus reset detected |

## Verification
The assertions assume the following about the master:
- it keeps od_i steady across a reset or slot;
- tx_en_i and tx_bit_i are settled before the falling edge that opens a slot;
- the line returns high before the next slot begins.

The stimulus keeps within these limits. It drives every input on the falling clock edge and draws each low time only from the legal ranges for the selected speed. It pads each slot out to at least the minimum slot length plus recovery, and changes speed only between complete transactions.

// File: rtl/swire_pkg.sv
package swire_pkg;

    // Timing set in microseconds; cycle counts are derived per module.
    localparam int STD_RST_US  = 360;  // reset cut, above any slot low time
    localparam int OD_RST_US   = 40;
    localparam int STD_SMP_US  = 30;   // write sample point after the edge
    localparam int OD_SMP_US   = 4;
    localparam int STD_HOLD_US = 45;   // read-0 hold after the edge
    localparam int OD_HOLD_US  = 6;
    localparam int STD_PDW_US  = 20;   // delay before presence
    localparam int OD_PDW_US   = 2;
    localparam int STD_PDL_US  = 100;  // presence length
    localparam int OD_PDL_US   = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOT,
        ST_RECOV,
        ST_RSTW,
        ST_PDW,
        ST_PDD
    } swire_st_e;

endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic fall_o
);
    localparam int SW = (STAGES < 2) ? 2 : STAGES;

    typedef struct packed {
        logic [SW-1:0] sh;
        logic          prev;
    } sync_t;

    sync_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.sh   = {r_q.sh[SW-2:0], line_i};
        r_d.prev = r_q.sh[SW-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{sh: '1, prev: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign lvl_o  = r_q.sh[SW-1];
    assign fall_o = r_q.prev & ~r_q.sh[SW-1];

endmodule

// File: rtl/swire_lowcnt.sv
module swire_lowcnt #(
    parameter int CLK_PER_US = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic od_i,
    output logic hit_o
);
    import swire_pkg::*;

    localparam int STD_C = STD_RST_US * CLK_PER_US;
    localparam int OD_C  = OD_RST_US * CLK_PER_US;
    localparam int CMAX  = STD_C + 1;
    localparam int CW    = $clog2(CMAX + 1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] thr;

    always_comb begin
        thr = od_i ? CW'(OD_C) : CW'(STD_C);
        if (lvl_i) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(CMAX)) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign hit_o = !lvl_i && (cnt_q == thr);

    AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o); // R2

endmodule

// File: rtl/swire_ctrl.sv
module swire_ctrl #(
    parameter int CLK_PER_US = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_i,
    input  logic       fall_i,
    input  logic       rst_hit_i,
    input  logic       od_i,
    input  logic       tx_en_i,
    input  logic       tx_bit_i,
    output logic       pull_o,
    output logic       rx_valid_o,
    output logic       rx_bit_o,
    output logic       tx_done_o,
    output logic [2:0] bit_pos_o,
    output logic       reset_seen_o
);
    import swire_pkg::*;

    localparam int TW = $clog2(STD_PDL_US * CLK_PER_US + 1);

    localparam logic [TW-1:0] SMP_S  = TW'(STD_SMP_US  * CLK_PER_US - 1);
    localparam logic [TW-1:0] SMP_O  = TW'(OD_SMP_US   * CLK_PER_US - 1);
    localparam logic [TW-1:0] HOLD_S = TW'(STD_HOLD_US * CLK_PER_US - 1);
    localparam logic [TW-1:0] HOLD_O = TW'(OD_HOLD_US  * CLK_PER_US - 1);
    localparam logic [TW-1:0] PDW_S  = TW'(STD_PDW_US  * CLK_PER_US - 1);
    localparam logic [TW-1:0] PDW_O  = TW'(OD_PDW_US   * CLK_PER_US - 1);
    localparam logic [TW-1:0] PDL_S  = TW'(STD_PDL_US  * CLK_PER_US - 1);
    localparam logic [TW-1:0] PDL_O  = TW'(OD_PDL_US   * CLK_PER_US - 1);

    typedef struct packed {
        swire_st_e      st;
        logic [TW-1:0]  tmr;
        logic           rd;
        logic           pull;
        logic           rx_valid;
        logic           rx_bit;
        logic           tx_done;
        logic           rst_seen;
        logic [2:0]     pos;
        logic [2:0]     pos_out;
    } ctrl_t;

    ctrl_t r_q, r_d;
    logic [TW-1:0] smp_c, hold_c, pdw_c, pdl_c;

    always_comb begin
        smp_c  = od_i ? SMP_O  : SMP_S;
        hold_c = od_i ? HOLD_O : HOLD_S;
        pdw_c  = od_i ? PDW_O  : PDW_S;
        pdl_c  = od_i ? PDL_O  : PDL_S;

        r_d          = r_q;
        r_d.rx_valid = 1'b0;
        r_d.tx_done  = 1'b0;
        r_d.rst_seen = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                if (fall_i) begin
                    r_d.st   = ST_SLOT;
                    r_d.tmr  = '0;
                    r_d.rd   = tx_en_i;
                    r_d.pull = tx_en_i & ~tx_bit_i;
                end
            end
            ST_SLOT: begin
                r_d.tmr = r_q.tmr + 1'b1;
                if (r_q.rd) begin
                    if (r_q.tmr == hold_c) begin
                        r_d.pull    = 1'b0;
                        r_d.tx_done = 1'b1;
                        r_d.pos_out = r_q.pos;
                        r_d.pos     = r_q.pos + 3'd1;
                        r_d.st      = ST_RECOV;
                    end
                end else if (r_q.tmr == smp_c) begin
                    r_d.rx_valid = 1'b1;
                    r_d.rx_bit   = lvl_i;
                    r_d.pos_out  = r_q.pos;
                    r_d.pos      = r_q.pos + 3'd1;
                    r_d.st       = ST_RECOV;
                end
            end
            ST_RECOV: begin
                if (lvl_i) begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_RSTW: begin
                if (lvl_i) begin
                    r_d.st  = ST_PDW;
                    r_d.tmr = '0;
                end
            end
            ST_PDW: begin
                r_d.tmr = r_q.tmr + 1'b1;
                if (r_q.tmr == pdw_c) begin
                    r_d.st   = ST_PDD;
                    r_d.tmr  = '0;
                    r_d.pull = 1'b1;
                end
            end
            ST_PDD: begin
                r_d.tmr = r_q.tmr + 1'b1;
                if (r_q.tmr == pdl_c) begin
                    r_d.pull = 1'b0;
                    r_d.st   = ST_RECOV;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        // A reset wins over anything in flight.
        if (rst_hit_i) begin
            r_d.st       = ST_RSTW;
            r_d.pull     = 1'b0;
            r_d.rd       = 1'b0;
            r_d.pos      = '0;
            r_d.rx_valid = 1'b0;
            r_d.tx_done  = 1'b0;
            r_d.rst_seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, tmr: '0, rd: 1'b0, pull: 1'b0,
                     rx_valid: 1'b0, rx_bit: 1'b0, tx_done: 1'b0,
                     rst_seen: 1'b0, pos: '0, pos_out: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign pull_o       = r_q.pull;
    assign rx_valid_o   = r_q.rx_valid;
    assign rx_bit_o     = r_q.rx_bit;
    assign tx_done_o    = r_q.tx_done;
    assign bit_pos_o    = r_q.pos_out;
    assign reset_seen_o = r_q.rst_seen;

    AST_WRITE_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SLOT && !r_q.rd) |-> !r_q.pull); // R10

    AST_RESET_ZERO_POS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_hit_i |=> (r_q.pos == 3'd0)); // R9

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({r_q.rx_valid, r_q.tx_done, r_q.rst_seen})); // R8

    AST_NO_SLOT_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !lvl_i) |-> !fall_i || r_d.st == ST_SLOT || rst_hit_i); // R5

endmodule

// File: rtl/swire_slave_phy.sv
module swire_slave_phy #(
    parameter int CLK_PER_US  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    input  logic       od_i,
    input  logic       tx_en_i,
    input  logic       tx_bit_i,
    output logic       pull_o,
    output logic       rx_valid_o,
    output logic       rx_bit_o,
    output logic       tx_done_o,
    output logic [2:0] bit_pos_o,
    output logic       reset_seen_o
);
    logic lvl;
    logic fall;
    logic rst_hit;

    swire_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_i),
        .lvl_o  (lvl),
        .fall_o (fall)
    );

    swire_lowcnt #(.CLK_PER_US(CLK_PER_US)) i_lowcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (lvl),
        .od_i  (od_i),
        .hit_o (rst_hit)
    );

    swire_ctrl #(.CLK_PER_US(CLK_PER_US)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .lvl_i        (lvl),
        .fall_i       (fall),
        .rst_hit_i    (rst_hit),
        .od_i         (od_i),
        .tx_en_i      (tx_en_i),
        .tx_bit_i     (tx_bit_i),
        .pull_o       (pull_o),
        .rx_valid_o   (rx_valid_o),
        .rx_bit_o     (rx_bit_o),
        .tx_done_o    (tx_done_o),
        .bit_pos_o    (bit_pos_o),
        .reset_seen_o (reset_seen_o)
    );

    AST_RESET_RELEASES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_seen_o |-> !pull_o); // R3

    AST_RESET_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        reset_seen_o |-> !lvl || $past(!lvl)); // R2

endmodule

// File: tb/test_swire_slave_phy.sv
module test_swire_slave_phy;

    localparam int CLK_PERIOD = 10;
    localparam int CPU        = 4;
    localparam int WDOG       = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_drive = 1'b0;
    logic       od = 1'b0;
    logic       tx_en = 1'b0;
    logic       tx_bit = 1'b1;
    logic       line;
    logic       pull_o, rx_valid_o, rx_bit_o, tx_done_o, reset_seen_o;
    logic [2:0] bit_pos_o;

    int  nchk = 0, nerr = 0;
    int  rx_cnt = 0, tx_cnt = 0, rst_cnt = 0, wr_pull = 0;
    bit  last_rx = 1'b0;
    int  last_pos = 0;
    bit  in_write = 1'b0;
    bit  done = 1'b0;
    logic [7:0] asm_byte = '0;

    assign line = ~(m_drive | pull_o);

    always #(CLK_PERIOD/2) clk = ~clk;

    swire_slave_phy #(.CLK_PER_US(CPU)) i_swire_slave_phy (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (line),
        .od_i         (od),
        .tx_en_i      (tx_en),
        .tx_bit_i     (tx_bit),
        .pull_o       (pull_o),
        .rx_valid_o   (rx_valid_o),
        .rx_bit_o     (rx_bit_o),
        .tx_done_o    (tx_done_o),
        .bit_pos_o    (bit_pos_o),
        .reset_seen_o (reset_seen_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid_o) begin
                rx_cnt++;
                last_rx  = rx_bit_o;
                last_pos = bit_pos_o;
                asm_byte[bit_pos_o] = rx_bit_o;
            end
            if (tx_done_o) begin
                tx_cnt++;
                last_pos = bit_pos_o;
            end
            if (reset_seen_o) rst_cnt++;
            if (in_write && pull_o) wr_pull++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (n * CPU) @(negedge clk);
    endtask

    function automatic bit exp_write(input int low_us, input bit sp);
        // write-1 range ends at 15 (std) / 2 (od); write-0 starts at 60 / 8
        return sp ? (low_us <= 2) : (low_us <= 15);
    endfunction

    function automatic int rest_us(input int used, input bit sp);
        int minslot = sp ? 30 : 90;
        int rec     = sp ? 4 : 10;
        return (minslot - used > rec) ? (minslot - used) : rec;
    endfunction

    task automatic bus_reset(input int low_us);
        int r0 = rst_cnt;
        m_drive = 1'b1;
        wait_us(low_us);
        chk(rst_cnt == r0 + 1, od ? "R4 od reset pulse" : "R2 std reset pulse", rst_cnt - r0, 1);
        m_drive = 1'b0;
        wait_us(od ? 8 : 66);
        chk(line == 1'b0, "R3 presence seen", int'(line), 0);
        wait_us(od ? 7 : 64);
        chk(pull_o == 1'b0, "R3 presence released", int'(pull_o), 0);
        wait_us(od ? 40 : 400);
        chk(rst_cnt == r0 + 1, "R2 single reset pulse", rst_cnt - r0, 1);
    endtask

    task automatic write_slot(input bit b, input int low_us);
        int c0 = rx_cnt, r0 = rst_cnt, p0 = wr_pull;
        bit e = exp_write(low_us, od);
        in_write = 1'b1;
        m_drive = 1'b1;
        wait_us(low_us);
        m_drive = 1'b0;
        wait_us(rest_us(low_us, od));
        in_write = 1'b0;
        chk(rx_cnt == c0 + 1, od ? "R6 one event" : "R5 one event", rx_cnt - c0, 1);
        chk(last_rx == e && e == b, od ? "R6 bit value" : "R5 bit value", int'(last_rx), int'(b));
        chk(rst_cnt == r0, "R4 no reset from slot", rst_cnt - r0, 0);
        chk(wr_pull == p0, "R10 no pull in write", wr_pull - p0, 0);
    endtask

    task automatic rand_write(input bit b);
        int lo;
        if (od) lo = b ? 1 + int'($urandom_range(1)) : 8 + int'($urandom_range(7));
        else    lo = b ? 1 + int'($urandom_range(14)) : 60 + int'($urandom_range(60));
        write_slot(b, lo);
    endtask

    task automatic read_slot(input bit b);
        int trl = od ? 1 + int'($urandom_range(1)) : 1 + int'($urandom_range(14));
        int t0 = tx_cnt, c0 = rx_cnt;
        tx_en = 1'b1;
        tx_bit = b;
        m_drive = 1'b1;
        wait_us(trl);
        m_drive = 1'b0;
        wait_us(od ? 2 : 15);
        chk(line == b, "R7 master reads bit", int'(line), int'(b));
        wait_us(rest_us(trl + (od ? 2 : 15), od));
        tx_en = 1'b0;
        tx_bit = 1'b1;
        chk(tx_cnt == t0 + 1 && rx_cnt == c0, "R7 one tx_done no rx", tx_cnt - t0, 1);
    endtask

    initial begin
        void'($urandom(32'h1d5e_a11c));
        repeat (3) @(negedge clk);
        chk(pull_o == 0 && rx_valid_o == 0 && tx_done_o == 0 && reset_seen_o == 0,
            "R1 reset state", int'({pull_o, rx_valid_o, tx_done_o, reset_seen_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pull_o == 0 && rx_valid_o == 0 && tx_done_o == 0 && reset_seen_o == 0,
            "R1 after release", int'({pull_o, rx_valid_o, tx_done_o, reset_seen_o}), 0);
        wait_us(5);

        // standard speed
        od = 1'b0;
        bus_reset(480 + int'($urandom_range(150)));
        write_slot(1'b1, 1);
        write_slot(1'b1, 15);
        write_slot(1'b0, 60);
        write_slot(1'b0, 120);
        // overdrive-length reset is only a write-0 at standard speed
        write_slot(1'b0, 50);

        // R9: reset mid-byte, then position restarts
        bus_reset(500);
        rand_write(1'b1);
        chk(last_pos == 0, "R9 pos after reset", last_pos, 0);
        rand_write(1'b0);
        rand_write(1'b1);
        bus_reset(480);
        rand_write(1'b0);
        chk(last_pos == 0, "R9 pos after mid-byte reset", last_pos, 0);

        // R8: byte LSB first at standard speed
        bus_reset(490);
        for (int k = 0; k < 2; k++) begin
            logic [7:0] byt = 8'($urandom);
            for (int i = 0; i < 8; i++) begin
                rand_write(byt[i]);
                chk(last_pos == i, "R8 bit position", last_pos, i);
            end
            chk(asm_byte == byt, "R8 byte rebuilt", int'(asm_byte), int'(byt));
        end
        for (int i = 0; i < 6; i++) read_slot(1'(i % 2));

        // overdrive
        od = 1'b1;
        bus_reset(48 + int'($urandom_range(20)));
        write_slot(1'b1, 1);
        write_slot(1'b1, 2);
        write_slot(1'b0, 8);
        write_slot(1'b0, 15);
        bus_reset(50);
        for (int k = 0; k < 3; k++) begin
            logic [7:0] byt = 8'($urandom);
            for (int i = 0; i < 8; i++) rand_write(byt[i]);
            chk(asm_byte == byt, "R8 od byte rebuilt", int'(asm_byte), int'(byt));
        end
        for (int i = 0; i < 8; i++) read_slot(1'($urandom_range(1)));
        chk(last_pos == 7, "R8 read slots advance position", last_pos, 7);
        read_slot(1'b0);
        chk(last_pos == 0, "R8 position wraps", last_pos, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule